// File: doc/BRIEF.md
# Byte Shift and Rotate Unit with Flag Update

This unit is the byte-wide shift and rotate stage of an integer execution datapath. It takes an 8-bit operand, a raw shift count, the incoming carry flag and an operation code. One clock edge after a start strobe it presents the new byte and the updated arithmetic flags. Each output has its own write enable, so a register file and a flags register can commit exactly the fields the operation defines and leave the rest alone.

Seven operations are supported: plain rotates left and right, rotates left and right through the carry, logical shifts left and right, and an arithmetic shift right. Counts are masked the usual way for byte operations. The two carry rotates work modulo nine because the carry takes part in the rotation. One odd case is kept on purpose: a plain rotate whose count is a nonzero multiple of eight writes no result but still refreshes carry and overflow from the unchanged operand.

Top module: `byte_shift_rotate_unit`

## Requirements
- R1: While reset (active low, synchronous) is asserted, and on the first edge after it, every write enable output is 0.
- R2: A start strobe sampled high on a rising edge updates the outputs and write enables on that edge. On an edge where start is low, every write enable goes to 0. Operation codes: 0 rotate left, 1 rotate right, 2 rotate left through carry, 3 rotate right through carry, 4 shift left, 5 logical shift right, 7 arithmetic shift right, and 6 behaves exactly like 4.
- R3: Only the low 5 bits of the raw count are used. If those 5 bits are zero, no write enable is raised, for every operation.
- R4: Rotate left by (count mod 8) with a nonzero amount writes the rotated byte and sets carry = result bit 0 and overflow = result bit 0 XOR result bit 7. Only carry and overflow are written.
- R5: Rotate right by (count mod 8) with a nonzero amount writes the rotated byte and sets carry = result bit 7 and overflow = result bit 6 XOR result bit 7. Only carry and overflow are written.
- R6: For a plain rotate whose masked count is 8, 16 or 24, the result write enable stays 0 while carry and overflow are written, using the rules of R4 or R5 applied to the unchanged operand.
- R7: Rotate left through carry rotates the 9-bit value {carry, operand} left by (masked count mod 9). The new carry is operand bit (8 - n), and overflow = new carry XOR result bit 7. An amount of 0 raises no enable. Only the result, carry and overflow are written.
- R8: Rotate right through carry rotates {carry, operand} right by (masked count mod 9). The new carry is operand bit (n - 1), and overflow = result bit 6 XOR result bit 7. An amount of 0 raises no enable. Only the result, carry and overflow are written.
- R9: Shift left by n = 1..8 gives operand << n, carry = operand bit (8 - n) and overflow = carry XOR result bit 7. For n = 9..31 the result, carry and overflow are all 0.
- R10: Logical shift right by n gives operand >> n, carry = operand bit (n - 1) (0 when n > 8) and overflow = result bit 6 XOR result bit 7.
- R11: Arithmetic shift right by n fills the vacated bits with operand bit 7. For n < 8 carry is operand bit (n - 1). For n >= 8 the result is eight copies of the sign and carry equals the sign. Overflow is always 0.
- R12: The three shifts write every flag: sign = result bit 7, zero = (result == 0), parity = 1 when the result holds an even number of ones, adjust = 0. The four rotates never raise the sign, zero, parity or adjust enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Execute the presented operation on this edge |
| op_sel | input | 3 | Operation code (see R2) |
| operand | input | 8 | Byte to shift or rotate |
| raw_count | input | 8 | Unmasked shift count |
| carry_in | input | 1 | Incoming carry flag |
| result | output | 8 | Shifted or rotated byte |
| result_we | output | 1 | Result valid for write-back |
| cf_out | output | 1 | New carry flag |
| of_out | output | 1 | New overflow flag |
| sf_out | output | 1 | New sign flag |
| zf_out | output | 1 | New zero flag |
| pf_out | output | 1 | New parity flag |
| af_out | output | 1 | New adjust flag |
| cf_we | output | 1 | Carry flag write enable |
| of_we | output | 1 | Overflow flag write enable |
| sf_we | output | 1 | Sign flag write enable |
| zf_we | output | 1 | Zero flag write enable |
| pf_we | output | 1 | Parity flag write enable |
| af_we | output | 1 | Adjust flag write enable |

## Verification
Random operands, operation codes, carries and 8-bit counts are drawn so that counts with bits above bit 4 set are common. These cases tell real masking apart from a full-width count. Directed cases hit the count boundaries that separate the rules: masked zero, 8 and 16 for plain rotates (no write, flags only), 9 and 18 against 10 for carry rotates (modulo nine), 8 against 9 for left shift, and 8 or more for an arithmetic shift of a negative byte. A one-bit logical right shift of a byte with the top bit set separates the overflow rule for a count of one from larger counts. Code 6 is checked against code 4, and an idle cycle confirms that the enables drop.

// File: rtl/shrot_pkg.sv
// Package: shared operation codes and flag bundle for the byte shift/rotate unit.
// Assumes: a 3-bit operation select; code 6 is an alias of the left shift.
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_ROL     = 3'd0,
        OP_ROR     = 3'd1,
        OP_RCL     = 3'd2,
        OP_RCR     = 3'd3,
        OP_SHL     = 3'd4,
        OP_SHR     = 3'd5,
        OP_SHL_ALT = 3'd6,
        OP_SAR     = 3'd7
    } shrot_op_e;

    // Flag bundle in a fixed field order shared by both datapaths
    typedef struct packed {
        logic cf;
        logic of;
        logic sf;
        logic zf;
        logic pf;
        logic af;
    } flag_vec_t;

endpackage

// File: rtl/shrot_rotator.sv
// Module: shrot_rotator
// Computes the four rotate operations (plain left/right, left/right through
// carry) combinationally, with result-write and flag-write qualifiers.
// Assumes: cnt is already masked; op_sel codes 0..3 select a rotate.
module shrot_rotator
    import shrot_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              carry_in,
    output logic [DATA_W-1:0] rot_res,
    output logic              rot_res_we,
    output logic              rot_flag_we,
    output logic              rot_cf,
    output logic              rot_of
);

    localparam int SUB_W = $clog2(DATA_W);
    localparam int RC_W  = DATA_W + 1;

    logic [SUB_W-1:0]    sub_cnt;
    logic [CNT_W-1:0]    rc_cnt;
    logic [2*DATA_W-1:0] dbl_left;
    logic [2*DATA_W-1:0] dbl_right;
    logic [RC_W-1:0]     rc_vec;
    logic [2*RC_W-1:0]   rc_dbl_left;
    logic [2*RC_W-1:0]   rc_dbl_right;
    logic [RC_W-1:0]     rcl_vec;
    logic [RC_W-1:0]     rcr_vec;
    logic [DATA_W-1:0]   plain_src;

    // Reduced amounts: plain rotates by cnt mod DATA_W, carry rotates by cnt mod RC_W
    always_comb begin
        sub_cnt = cnt[SUB_W-1:0];
        rc_cnt  = cnt % CNT_W'(RC_W);
    end

    // Rotated candidates built from doubled vectors
    always_comb begin
        dbl_left     = {operand, operand} << sub_cnt;
        dbl_right    = {operand, operand} >> sub_cnt;
        rc_vec       = {carry_in, operand};
        rc_dbl_left  = {rc_vec, rc_vec} << rc_cnt;
        rc_dbl_right = {rc_vec, rc_vec} >> rc_cnt;
        rcl_vec      = rc_dbl_left[2*RC_W-1:RC_W];
        rcr_vec      = rc_dbl_right[RC_W-1:0];
    end

    // Select the rotate outcome and its carry/overflow rules
    always_comb begin
        rot_res     = operand;
        rot_res_we  = 1'b0;
        rot_flag_we = 1'b0;
        rot_cf      = 1'b0;
        rot_of      = 1'b0;
        plain_src   = operand;
        unique case (shrot_op_e'(op_sel))
            OP_ROL: begin
                plain_src   = (sub_cnt == '0) ? operand : dbl_left[2*DATA_W-1:DATA_W];
                rot_res     = plain_src;
                rot_res_we  = (sub_cnt != '0);
                rot_flag_we = (cnt != '0);
                rot_cf      = plain_src[0];
                rot_of      = plain_src[0] ^ plain_src[DATA_W-1];
            end
            OP_ROR: begin
                plain_src   = (sub_cnt == '0) ? operand : dbl_right[DATA_W-1:0];
                rot_res     = plain_src;
                rot_res_we  = (sub_cnt != '0);
                rot_flag_we = (cnt != '0);
                rot_cf      = plain_src[DATA_W-1];
                rot_of      = plain_src[DATA_W-2] ^ plain_src[DATA_W-1];
            end
            OP_RCL: begin
                rot_res     = rcl_vec[DATA_W-1:0];
                rot_res_we  = (rc_cnt != '0);
                rot_flag_we = (rc_cnt != '0);
                rot_cf      = rcl_vec[DATA_W];
                rot_of      = rcl_vec[DATA_W] ^ rcl_vec[DATA_W-1];
            end
            OP_RCR: begin
                rot_res     = rcr_vec[DATA_W-1:0];
                rot_res_we  = (rc_cnt != '0);
                rot_flag_we = (rc_cnt != '0);
                rot_cf      = rcr_vec[DATA_W];
                rot_of      = rcr_vec[DATA_W-2] ^ rcr_vec[DATA_W-1];
            end
            default: begin
                rot_res = operand;
            end
        endcase
    end

endmodule

// File: rtl/shrot_shifter.sv
// Module: shrot_shifter
// Computes the three shifts (left, logical right, arithmetic right) and their
// full flag set through one wide shifter per direction.
// Assumes: cnt is already masked; codes 4 and 6 are both the left shift.
module shrot_shifter
    import shrot_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] sh_res,
    output flag_vec_t         sh_flags
);

    localparam int PAD_W = 1 << CNT_W;
    localparam int EXT_W = DATA_W + PAD_W;

    logic [EXT_W-1:0] ext_left;
    logic [EXT_W-1:0] ext_lright;
    logic [EXT_W-1:0] ext_aright;
    logic             sh_cf;
    logic             sh_of;

    // Wide shifts keep every bit shifted out, so the carry is one fixed position
    always_comb begin
        ext_left   = {{PAD_W{1'b0}}, operand} << cnt;
        ext_lright = {operand, {PAD_W{1'b0}}} >> cnt;
        ext_aright = $unsigned($signed({operand, {PAD_W{1'b0}}}) >>> cnt);
    end

    // Pick the shift and its carry/overflow
    always_comb begin
        unique case (shrot_op_e'(op_sel))
            OP_SHR: begin
                sh_res = ext_lright[EXT_W-1 -: DATA_W];
                sh_cf  = ext_lright[PAD_W-1];
                sh_of  = sh_res[DATA_W-1] ^ sh_res[DATA_W-2];
            end
            OP_SAR: begin
                sh_res = ext_aright[EXT_W-1 -: DATA_W];
                sh_cf  = ext_aright[PAD_W-1];
                sh_of  = 1'b0;
            end
            default: begin
                sh_res = ext_left[DATA_W-1:0];
                sh_cf  = ext_left[DATA_W];
                sh_of  = ext_left[DATA_W] ^ ext_left[DATA_W-1];
            end
        endcase
    end

    // Logic-style result flags
    always_comb begin
        sh_flags.cf = sh_cf;
        sh_flags.of = sh_of;
        sh_flags.sf = sh_res[DATA_W-1];
        sh_flags.zf = (sh_res == '0);
        sh_flags.pf = ~^sh_res;
        sh_flags.af = 1'b0;
    end

endmodule

// File: rtl/byte_shift_rotate_unit.sv
// Module: byte_shift_rotate_unit
// Top of the byte shift/rotate stage: masks the count, selects between the
// rotate and shift datapaths, and registers result, flags and write enables
// on the edge where start is sampled high.
// Assumes: synchronous active-low reset; enables are one-cycle pulses and the
// value outputs hold between operations for fields that were not written.
module byte_shift_rotate_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int RAW_CNT_W = 8,
    parameter int CNT_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2:0]           op_sel,
    input  logic [DATA_W-1:0]    operand,
    input  logic [RAW_CNT_W-1:0] raw_count,
    input  logic                 carry_in,
    output logic [DATA_W-1:0]    result,
    output logic                 result_we,
    output logic                 cf_out,
    output logic                 of_out,
    output logic                 sf_out,
    output logic                 zf_out,
    output logic                 pf_out,
    output logic                 af_out,
    output logic                 cf_we,
    output logic                 of_we,
    output logic                 sf_we,
    output logic                 zf_we,
    output logic                 pf_we,
    output logic                 af_we
);

    localparam int NFLAG = $bits(flag_vec_t);

    logic [CNT_W-1:0]  cnt_m;
    logic              is_rotate;
    logic [DATA_W-1:0] rot_res;
    logic              rot_res_we;
    logic              rot_flag_we;
    logic              rot_cf;
    logic              rot_of;
    logic [DATA_W-1:0] sh_res;
    flag_vec_t         sh_flags;
    logic [DATA_W-1:0] nxt_res;
    logic              nxt_res_we;
    flag_vec_t         nxt_flags;
    flag_vec_t         nxt_we;
    flag_vec_t         flags_q;
    flag_vec_t         we_q;

    // Count masking and datapath class
    always_comb begin
        cnt_m     = raw_count[CNT_W-1:0];
        is_rotate = ~op_sel[2];
    end

    shrot_rotator #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_rot (
        .op_sel      (op_sel),
        .operand     (operand),
        .cnt         (cnt_m),
        .carry_in    (carry_in),
        .rot_res     (rot_res),
        .rot_res_we  (rot_res_we),
        .rot_flag_we (rot_flag_we),
        .rot_cf      (rot_cf),
        .rot_of      (rot_of)
    );

    shrot_shifter #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_sh (
        .op_sel   (op_sel),
        .operand  (operand),
        .cnt      (cnt_m),
        .sh_res   (sh_res),
        .sh_flags (sh_flags)
    );

    // Merge the two datapaths into next-state value and enable bundles
    always_comb begin
        if (is_rotate) begin
            nxt_res      = rot_res;
            nxt_res_we   = rot_res_we;
            nxt_flags    = '0;
            nxt_flags.cf = rot_cf;
            nxt_flags.of = rot_of;
            nxt_we       = '0;
            nxt_we.cf    = rot_flag_we;
            nxt_we.of    = rot_flag_we;
        end else begin
            nxt_res    = sh_res;
            nxt_res_we = (cnt_m != '0);
            nxt_flags  = sh_flags;
            nxt_we     = (cnt_m != '0) ? {NFLAG{1'b1}} : '0;
        end
    end

    // Output registers: enables pulse with start, values load only when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            result_we <= 1'b0;
            flags_q   <= '0;
            we_q      <= '0;
        end else begin
            result_we <= start & nxt_res_we;
            we_q      <= start ? nxt_we : '0;
            if (start && nxt_res_we) begin
                result <= nxt_res;
            end
            for (int i = 0; i < NFLAG; i++) begin
                if (start && nxt_we[i]) begin
                    flags_q[i] <= nxt_flags[i];
                end
            end
        end
    end

    // Unpack registered bundles onto ports
    always_comb begin
        cf_out = flags_q.cf;
        of_out = flags_q.of;
        sf_out = flags_q.sf;
        zf_out = flags_q.zf;
        pf_out = flags_q.pf;
        af_out = flags_q.af;
        cf_we  = we_q.cf;
        of_we  = we_q.of;
        sf_we  = we_q.sf;
        zf_we  = we_q.zf;
        pf_we  = we_q.pf;
        af_we  = we_q.af;
    end

    // ---------------- assertions ----------------
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !result_we && !cf_we && !of_we && !sf_we && !zf_we && !pf_we && !af_we)
        else $error("R2: enable raised without start");

    assert_zero_count_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start && (raw_count[CNT_W-1:0] == '0)
        |=> !result_we && !cf_we && !of_we && !sf_we && !zf_we && !pf_we && !af_we)
        else $error("R3: enable raised for zero masked count");

    assert_rol_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start && (op_sel == 3'd0) && (raw_count[2:0] != 3'd0)
        |=> result_we && cf_we && (cf_out == result[0]) && (of_out == (result[0] ^ result[DATA_W-1])))
        else $error("R4: rotate-left flags disagree with result");

    assert_plain_rotate_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start && !op_sel[1] && !op_sel[2] && (raw_count[2:0] == 3'd0) && (raw_count[CNT_W-1:3] != '0)
        |=> !result_we && cf_we && of_we)
        else $error("R6: plain rotate by multiple of eight misbehaved");

    assert_shl_wide_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start && (op_sel[2:1] == 2'b10 || op_sel == 3'd6) && (op_sel != 3'd5) && (raw_count[CNT_W-1:0] > CNT_W'(DATA_W))
        |=> result_we && (result == '0) && !cf_out && !of_out && zf_out)
        else $error("R9: long left shift not cleared");

    assert_sar_sign_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start && (op_sel == 3'd7) && (raw_count[CNT_W-1:0] != '0)
        |=> of_we && !of_out && (result[DATA_W-1] == $past(operand[DATA_W-1])))
        else $error("R11: arithmetic shift lost sign or set overflow");

    assert_rotate_keeps_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start && !op_sel[2] |=> !sf_we && !zf_we && !pf_we && !af_we)
        else $error("R12: rotate wrote a result flag");

endmodule

// File: tb/tb_byte_shift_rotate_unit.sv
// Bench: directed corner cases plus seeded random traffic, checked against a
// bit-serial reference model written from the requirements.
module tb_byte_shift_rotate_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [2:0] op_sel;
    logic [7:0] operand;
    logic [7:0] raw_count;
    logic       carry_in;
    logic [7:0] result;
    logic       result_we, cf_out, of_out, sf_out, zf_out, pf_out, af_out;
    logic       cf_we, of_we, sf_we, zf_we, pf_we, af_we;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    byte_shift_rotate_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .operand(operand), .raw_count(raw_count), .carry_in(carry_in),
        .result(result), .result_we(result_we),
        .cf_out(cf_out), .of_out(of_out), .sf_out(sf_out),
        .zf_out(zf_out), .pf_out(pf_out), .af_out(af_out),
        .cf_we(cf_we), .of_we(of_we), .sf_we(sf_we),
        .zf_we(zf_we), .pf_we(pf_we), .af_we(af_we)
    );

    // Expected outcome: we = {res,cf,of,sf,zf,pf,af}, flg = {cf,of,sf,zf,pf,af}
    typedef struct packed {
        logic [6:0] we;
        logic [7:0] res;
        logic [5:0] flg;
    } exp_t;

    // Bit-serial reference: one single-bit step per count
    function automatic exp_t model(input logic [2:0] op, input logic [7:0] a,
                                   input logic [7:0] raw, input logic cin);
        exp_t e;
        int n5;
        int n;
        logic [7:0] r;
        logic c;
        logic o;
        e  = '0;
        n5 = int'(raw[4:0]);
        r  = a;
        c  = 1'b0;
        o  = 1'b0;
        if (n5 == 0) return e;
        case (op)
            3'd0, 3'd1: begin
                n = n5 % 8;
                for (int k = 0; k < n; k++)
                    r = (op == 3'd0) ? {r[6:0], r[7]} : {r[0], r[7:1]};
                if (op == 3'd0) begin c = r[0]; o = r[0] ^ r[7]; end
                else            begin c = r[7]; o = r[6] ^ r[7]; end
                e.we  = {(n != 0), 6'b110000};
                e.res = r;
                e.flg = {c, o, 4'b0};
            end
            3'd2, 3'd3: begin
                n = n5 % 9;
                if (n == 0) return e;
                c = cin;
                for (int k = 0; k < n; k++)
                    if (op == 3'd2) {c, r} = {r, c};
                    else            {r, c} = {c, r};
                o = (op == 3'd2) ? (c ^ r[7]) : (r[6] ^ r[7]);
                e.we  = 7'b1110000;
                e.res = r;
                e.flg = {c, o, 4'b0};
            end
            default: begin
                for (int k = 0; k < n5; k++) begin
                    if (op == 3'd5)      {r, c} = {1'b0, r};
                    else if (op == 3'd7) {r, c} = {r[7], r};
                    else                 {c, r} = {r, 1'b0};
                end
                if (op == 3'd5)      o = r[6] ^ r[7];
                else if (op == 3'd7) o = 1'b0;
                else                 o = c ^ r[7];
                e.we  = 7'b1111111;
                e.res = r;
                e.flg = {c, o, r[7], (r == 8'h00), ~^r, 1'b0};
            end
        endcase
        return e;
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R7";
            3'd3: return "R8";
            3'd5: return "R10";
            3'd7: return "R11";
            default: return "R9";
        endcase
    endfunction

    // Compare registered outputs with the expectation on fields that are enabled
    task automatic compare(input exp_t e, input string req);
        logic [6:0] got_we;
        logic [5:0] got_flg;
        bit bad;
        got_we  = {result_we, cf_we, of_we, sf_we, zf_we, pf_we, af_we};
        got_flg = {cf_out, of_out, sf_out, zf_out, pf_out, af_out};
        bad = (got_we != e.we) || ((got_flg & e.we[5:0]) != (e.flg & e.we[5:0]))
              || (e.we[6] && (result != e.res));
        n_tests++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: we=%b res=%h flg=%b expected we=%b res=%h flg=%b",
                     req, got_we, result, got_flg & e.we[5:0], e.we, e.res, e.flg & e.we[5:0]);
        end
    endtask

    // One operation: drive at negedge, sample at the following negedge
    task automatic run_op(input logic [2:0] op, input logic [7:0] a,
                          input logic [7:0] raw, input logic cin, input string req);
        exp_t e;
        op_sel    = op;
        operand   = a;
        raw_count = raw;
        carry_in  = cin;
        start     = 1'b1;
        e = model(op, a, raw, cin);
        @(negedge clk);
        start = 1'b0;
        compare(e, req);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        exp_t idle;
        idle = '0;
        void'($urandom(32'd1234));
        rst_n = 1'b0; start = 1'b0; op_sel = '0; operand = '0; raw_count = '0; carry_in = 1'b0;
        repeat (3) @(negedge clk);
        compare(idle, "R1");          // enables low in reset
        rst_n = 1'b1;
        @(negedge clk);
        compare(idle, "R1");          // and after release

        run_op(3'd0, 8'h81, 8'd1, 1'b0, "R4");
        run_op(3'd0, 8'h81, 8'd8, 1'b0, "R6");   // ROL by 8: flags only
        run_op(3'd1, 8'h40, 8'd16, 1'b1, "R6");  // ROR by 16: flags only
        run_op(3'd1, 8'h01, 8'd3, 1'b0, "R5");
        run_op(3'd0, 8'hA5, 8'h20, 1'b1, "R3");  // masked count 0
        run_op(3'd5, 8'hA5, 8'hE0, 1'b1, "R3");
        run_op(3'd2, 8'h5A, 8'd9, 1'b1, "R7");   // mod 9 -> 0
        run_op(3'd2, 8'h80, 8'd10, 1'b1, "R7");  // mod 9 -> 1
        run_op(3'd3, 8'h01, 8'd18, 1'b0, "R8");  // mod 9 -> 0
        run_op(3'd3, 8'h03, 8'd2, 1'b1, "R8");
        run_op(3'd4, 8'h01, 8'd8, 1'b0, "R9");
        run_op(3'd4, 8'hFF, 8'd9, 1'b1, "R9");
        run_op(3'd6, 8'h41, 8'd1, 1'b0, "R2");   // code 6 as left shift
        run_op(3'd5, 8'h80, 8'd1, 1'b0, "R10");  // overflow = old bit 7
        run_op(3'd5, 8'hC0, 8'd2, 1'b0, "R10");
        run_op(3'd7, 8'h90, 8'd8, 1'b0, "R11");
        run_op(3'd7, 8'h7F, 8'd31, 1'b1, "R11");
        run_op(3'd4, 8'h00, 8'd3, 1'b0, "R12");  // zero and parity
        @(negedge clk);
        compare(idle, "R2");                     // idle edge drops enables

        for (int i = 0; i < 400; i++) begin
            logic [2:0] op;
            op = 3'($urandom);
            run_op(op, 8'($urandom), 8'($urandom), 1'($urandom), req_of(op));
            if (($urandom % 4) == 0) begin
                @(negedge clk);
                compare(idle, "R2");
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule